// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block sits between a CPU's interrupt-acknowledge strobe and the priority logic of an interrupt controller. It counts acknowledge pulses and fixes the winning level at the first one. On each pulse it places the matching vector byte on the data bus. It also tells the priority block when to freeze, when to mark the level in service, and when to issue an automatic end-of-interrupt.

Two processor modes are supported:
- **8-bit mode:** a three-pulse sequence. The pulses return a call opcode, then a low address byte packed by the level and address interval, then a high byte.
- **16-bit mode:** a two-pulse sequence. The first pulse leaves the bus idle. The second returns a type byte.

In a cascaded system the block acts as master or slave:
- **Master:** it broadcasts the serviced level on three cascade lines. It leaves the vector bytes to the addressed slave.
- **Slave:** it answers only when the cascade input carries its own ID.

When no request is valid at the first pulse, the block answers as if level 7 had been acknowledged.

Top module: `ackSeqTop`

## Requirements
- R1: In 8-bit mode (cpu16=0), pulse 1 drives 0xCD, pulse 2 drives the low address byte and pulse 3 drives hiByte, each only while the strobe is low.
- R2: Low address byte: with interval4=1 it is {addrLow[2:0], level, 2'b00}; with interval4=0 it is {addrLow[2:1], level, 3'b000}.
- R3: In 16-bit mode (cpu16=1), pulse 1 drives nothing (dataOe=0) and pulse 2 drives {hiByte[7:3], level}. interval4 has no effect.
- R4: The level (reqLevel, or 7 when reqValid=0) is captured at the first falling strobe edge. freezePulse is high for one cycle right after that edge. Later changes of reqLevel or reqValid do not alter the sequence.
- R5: setIsPulse is high for one cycle, with setIsLevel equal to the captured level. It follows the first falling edge in 16-bit mode and the second falling edge in 8-bit mode.
- R6: With reqValid=0 at the first pulse, vector bytes and cascade lines use level 7 and setIsPulse never fires.
- R7: With autoEoi=1, autoEoiPulse is high for one cycle after the rising edge of the last pulse (pulse 3 in 8-bit mode, pulse 2 in 16-bit mode), and at no other time.
- R8: As master, when slaveCfg[level]=1, casOut carries the level from the end of pulse 1 until the end of the last pulse. At all other times casOut=0. casOe equals the master role.
- R9: As master, vector bytes (every byte except the opcode) are not driven when slaveCfg[level]=1. The opcode is always driven by the master.
- R10: As slave, the opcode is never driven, and vector bytes are driven only while casIn equals slaveCfg[2:0].
- R11: The role is bufMaster when bufMode=1, else rolePin. bufEnN is low exactly when bufMode=1 and dataOe=1, otherwise high.
- R12: After the last pulse the counter is idle, so the next falling edge starts a new sequence. initStart returns the counter to idle at any point.
- R13: After reset, dataOe=0, dataOut=0, casOut=0, bufEnN=1 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| ackN | input | 1 | acknowledge strobe, active low, synchronous |
| initStart | input | 1 | first initialization word written; aborts the sequence |
| reqValid | input | 1 | a resolved request exists |
| reqLevel | input | 3 | resolved request level |
| cpu16 | input | 1 | 1: two-pulse 16-bit mode, 0: three-pulse 8-bit mode |
| interval4 | input | 1 | 1: address interval 4, 0: interval 8 |
| addrLow | input | 3 | programmed address bits 7..5 |
| hiByte | input | 8 | high vector byte / type base |
| bufMode | input | 1 | buffered mode |
| bufMaster | input | 1 | role in buffered mode (1 master) |
| rolePin | input | 1 | role pin used when not buffered (1 master) |
| slaveCfg | input | 8 | master: slave map per level; slave: ID in bits 2..0 |
| autoEoi | input | 1 | automatic end-of-interrupt enable |
| casIn | input | 3 | cascade address input |
| dataOut | output | 8 | data bus value |
| dataOe | output | 1 | data bus drive enable |
| casOut | output | 3 | cascade address output |
| casOe | output | 1 | cascade lines driven (master) |
| bufEnN | output | 1 | buffer enable, active low |
| freezePulse | output | 1 | freeze priority state |
| setIsPulse | output | 1 | set in-service bit |
| setIsLevel | output | 3 | level for setIsPulse |
| autoEoiPulse | output | 1 | non-specific end-of-interrupt request |

## Verification
A pulse counter one step off would show at the very next low strobe as the wrong byte: the opcode where a low address byte belongs, or a driven bus in the silent first 16-bit pulse. A wrongly captured level corrupts the level field of the following vector byte and the cascade value within one pulse. A stuck cascade flag leaves casOut nonzero in the idle cycle after the last pulse. Random configurations change the level and request validity after pulse 1 to expose any failure to freeze.

// File: rtl/ackSeqPkg.sv
package ackSeqPkg;
  localparam int LVL_W  = 3;
  localparam int DATA_W = 8;
  localparam int PH_W   = 2;
  localparam logic [DATA_W-1:0] CALL_OP = 8'hCD;
  localparam logic [LVL_W-1:0]  DEFAULT_LVL = '1;

  typedef struct packed {
    logic [PH_W-1:0]  phase;     // 0 idle, else current pulse number
    logic             ackLow;    // strobe registered low
    logic [LVL_W-1:0] lvl;       // frozen level
    logic             casActive; // master broadcasts lvl
  } seqCtl_t;
endpackage

// File: rtl/ackSeqCtrl.sv
module ackSeqCtrl
  import ackSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackN,
  input  logic              initStart,
  input  logic              reqValid,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic              cpu16,
  input  logic              autoEoi,
  input  logic              isMaster,
  input  logic [(1<<LVL_W)-1:0] slaveMap,
  output seqCtl_t           ctl,
  output logic              freezePulse,
  output logic              setIsPulse,
  output logic [LVL_W-1:0]  setIsLevel,
  output logic              autoEoiPulse
);
  logic ackQ;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastPhase;
  logic [LVL_W-1:0] lvl;
  logic spurious;
  logic casAct;
  logic fallEdge, riseEdge;

  assign fallEdge  = ackQ & ~ackN;
  assign riseEdge  = ~ackQ & ackN;
  assign lastPhase = cpu16 ? PH_W'(2) : PH_W'(3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ         <= 1'b1;
      phase        <= '0;
      lvl          <= DEFAULT_LVL;
      spurious     <= 1'b0;
      casAct       <= 1'b0;
      freezePulse  <= 1'b0;
      setIsPulse   <= 1'b0;
      setIsLevel   <= '0;
      autoEoiPulse <= 1'b0;
    end else begin
      ackQ         <= ackN;
      freezePulse  <= 1'b0;
      setIsPulse   <= 1'b0;
      autoEoiPulse <= 1'b0;
      if (initStart) begin
        phase  <= '0;
        casAct <= 1'b0;
      end else if (fallEdge) begin
        if (phase == '0) begin
          phase       <= PH_W'(1);
          lvl         <= reqValid ? reqLevel : DEFAULT_LVL;
          spurious    <= ~reqValid;
          freezePulse <= 1'b1;
          if (cpu16 && reqValid) begin
            setIsPulse <= 1'b1;
            setIsLevel <= reqLevel;
          end
        end else begin
          phase <= phase + PH_W'(1);
          if (!cpu16 && phase == PH_W'(1) && !spurious) begin
            setIsPulse <= 1'b1;
            setIsLevel <= lvl;
          end
        end
      end else if (riseEdge && phase != '0) begin
        if (phase == lastPhase) begin
          phase        <= '0;
          casAct       <= 1'b0;
          autoEoiPulse <= autoEoi;
        end else if (phase == PH_W'(1)) begin
          casAct <= isMaster & slaveMap[lvl];
        end
      end
    end
  end

  assign ctl.phase     = phase;
  assign ctl.ackLow    = ~ackQ;
  assign ctl.lvl       = lvl;
  assign ctl.casActive = casAct;
endmodule

// File: rtl/ackSeqData.sv
module ackSeqData
  import ackSeqPkg::*;
(
  input  seqCtl_t              ctl,
  input  logic                 cpu16,
  input  logic                 interval4,
  input  logic [2:0]           addrLow,
  input  logic [DATA_W-1:0]    hiByte,
  input  logic                 isMaster,
  input  logic [(1<<LVL_W)-1:0] slaveCfg,
  input  logic [LVL_W-1:0]     casIn,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe,
  output logic [LVL_W-1:0]     casOut
);
  logic isOpcode, isVector, mayDrive;
  logic [DATA_W-1:0] lowByte, selByte;

  always_comb begin
    isOpcode = !cpu16 && ctl.phase == PH_W'(1);
    isVector = cpu16 ? (ctl.phase == PH_W'(2)) : (ctl.phase >= PH_W'(2));
    lowByte  = interval4 ? {addrLow, ctl.lvl, 2'b00}
                         : {addrLow[2:1], ctl.lvl, 3'b000};
    if (isOpcode)                    selByte = CALL_OP;
    else if (cpu16)                  selByte = {hiByte[7:3], ctl.lvl};
    else if (ctl.phase == PH_W'(2))  selByte = lowByte;
    else                             selByte = hiByte;
    if (isOpcode)      mayDrive = isMaster;
    else if (isVector) mayDrive = isMaster ? ~slaveCfg[ctl.lvl]
                                           : (casIn == slaveCfg[LVL_W-1:0]);
    else               mayDrive = 1'b0;
    dataOe  = ctl.ackLow && ctl.phase != '0 && mayDrive;
    dataOut = dataOe ? selByte : '0;
    casOut  = ctl.casActive ? ctl.lvl : '0;
  end
endmodule

// File: rtl/ackSeqTop.sv
module ackSeqTop
  import ackSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackN,
  input  logic       initStart,
  input  logic       reqValid,
  input  logic [2:0] reqLevel,
  input  logic       cpu16,
  input  logic       interval4,
  input  logic [2:0] addrLow,
  input  logic [7:0] hiByte,
  input  logic       bufMode,
  input  logic       bufMaster,
  input  logic       rolePin,
  input  logic [7:0] slaveCfg,
  input  logic       autoEoi,
  input  logic [2:0] casIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic [2:0] casOut,
  output logic       casOe,
  output logic       bufEnN,
  output logic       freezePulse,
  output logic       setIsPulse,
  output logic [2:0] setIsLevel,
  output logic       autoEoiPulse
);
  seqCtl_t ctl;
  logic isMaster;

  assign isMaster = bufMode ? bufMaster : rolePin;
  assign casOe    = isMaster;
  assign bufEnN   = ~(bufMode & dataOe);

  ackSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackN(ackN), .initStart(initStart),
    .reqValid(reqValid), .reqLevel(reqLevel), .cpu16(cpu16),
    .autoEoi(autoEoi), .isMaster(isMaster), .slaveMap(slaveCfg),
    .ctl(ctl), .freezePulse(freezePulse), .setIsPulse(setIsPulse),
    .setIsLevel(setIsLevel), .autoEoiPulse(autoEoiPulse)
  );

  ackSeqData u_data (
    .ctl(ctl), .cpu16(cpu16), .interval4(interval4), .addrLow(addrLow),
    .hiByte(hiByte), .isMaster(isMaster), .slaveCfg(slaveCfg),
    .casIn(casIn), .dataOut(dataOut), .dataOe(dataOe), .casOut(casOut)
  );
endmodule

// File: rtl/ackSeqChk.sv
module ackSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       ackN,
  input logic       bufMode,
  input logic       dataOe,
  input logic [2:0] casOut,
  input logic       casOe,
  input logic       bufEnN,
  input logic       freezePulse,
  input logic       setIsPulse,
  input logic       autoEoiPulse
);
  // R4
  freeze_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezePulse |-> !$past(ackN));
  // R5
  setis_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    setIsPulse |-> !$past(ackN));
  // R7
  aeoi_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoEoiPulse |-> $past(ackN));
  // R8
  cas_master_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (casOut != 3'd0) |-> casOe);
  // R11
  bufen_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && dataOe) |-> !bufEnN);
  // R11
  bufen_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> bufEnN);
  // R1
  drive_only_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !$past(ackN));
endmodule

bind ackSeqTop ackSeqChk u_chk (.*);

// File: tb/sim_ackSeqTop.sv
module sim_ackSeqTop;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, ackN = 1'b1, initStart = 1'b0;
  logic reqValid = 1'b0, cpu16 = 1'b0, interval4 = 1'b0;
  logic [2:0] reqLevel = '0, addrLow = '0, casIn = '0;
  logic [7:0] hiByte = '0, slaveCfg = '0;
  logic bufMode = 1'b0, bufMaster = 1'b0, rolePin = 1'b1, autoEoi = 1'b0;
  logic [7:0] dataOut;
  logic dataOe, casOe, bufEnN, freezePulse, setIsPulse, autoEoiPulse;
  logic [2:0] casOut, setIsLevel;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  ackSeqTop u0 (.*);

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic isMasterF();
    return bufMode ? bufMaster : rolePin;
  endfunction

  // expected {oe, data} for pulse p at level lv
  function automatic logic [8:0] expBus(int p, logic [2:0] lv);
    logic opc, vec, oe;
    logic [7:0] d;
    opc = !cpu16 && p == 1;
    vec = cpu16 ? (p == 2) : (p >= 2);
    if (opc) d = 8'hCD;
    else if (cpu16) d = {hiByte[7:3], lv};
    else if (p == 2) d = interval4 ? {addrLow, lv, 2'b00} : {addrLow[2:1], lv, 3'b000};
    else d = hiByte;
    if (opc) oe = isMasterF();
    else if (vec) oe = isMasterF() ? !slaveCfg[lv] : (casIn == slaveCfg[2:0]);
    else oe = 1'b0;
    return {oe, oe ? d : 8'h00};
  endfunction

  task automatic runSeq();
    int last;
    logic [2:0] lv;
    logic spur, casSel;
    logic [8:0] e;
    last   = cpu16 ? 2 : 3;
    lv     = reqValid ? reqLevel : 3'd7;
    spur   = !reqValid;
    casSel = isMasterF() && slaveCfg[lv];
    for (int p = 1; p <= last; p++) begin
      @(negedge clk) ackN = 1'b0;
      @(negedge clk);
      e = expBus(p, lv);
      chk($sformatf("R1 R2 R3 R9 R10 R6 bus p%0d", p), {dataOe, dataOut}, e);
      chk("R11 bufEnN", {8'h0, bufEnN}, {8'h0, !(bufMode && e[8])});
      chk("R4 freezePulse", {8'h0, freezePulse}, {8'h0, p == 1});
      chk("R5 R6 setIs", {5'h0, setIsPulse, setIsLevel},
          (((cpu16 ? p == 1 : p == 2) && !spur)) ? {5'h0, 1'b1, lv} : {5'h0, 1'b0, setIsLevel});
      chk("R8 casOut low", {6'h0, casOut}, {6'h0, (p > 1 && casSel) ? lv : 3'd0});
      chk("R8 casOe", {8'h0, casOe}, {8'h0, isMasterF()});
      if (p == 1) begin // R4: disturb inputs after freeze
        reqLevel = 3'($urandom);
        reqValid = 1'($urandom);
      end
      @(negedge clk) ackN = 1'b1;
      @(negedge clk);
      chk("R7 autoEoiPulse", {8'h0, autoEoiPulse}, {8'h0, (p == last) && autoEoi});
      chk("R8 casOut high", {6'h0, casOut}, {6'h0, (p < last && casSel) ? lv : 3'd0});
      chk("R1 idle bus", {dataOe, dataOut}, 9'h0);
    end
    @(negedge clk);
  endtask

  task automatic randCfg();
    cpu16     = 1'($urandom);
    interval4 = 1'($urandom);
    addrLow   = 3'($urandom);
    hiByte    = 8'($urandom);
    bufMode   = 1'($urandom);
    bufMaster = 1'($urandom);
    rolePin   = 1'($urandom);
    slaveCfg  = 8'($urandom);
    autoEoi   = 1'($urandom);
    reqLevel  = 3'($urandom);
    reqValid  = ($urandom % 4) != 0;
    casIn     = 1'($urandom) ? slaveCfg[2:0] : 3'($urandom);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset bus", {dataOe, dataOut}, 9'h0);
    chk("R13 reset misc", {3'h0, casOut, bufEnN, freezePulse, setIsPulse},
        {3'h0, 3'd0, 1'b1, 1'b0, 1'b0});
    chk("R13 reset aeoi", {8'h0, autoEoiPulse}, 9'h0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: 8-bit master, interval 4, level 5
    cpu16 = 0; interval4 = 1; addrLow = 3'b101; hiByte = 8'hA7; rolePin = 1;
    slaveCfg = 8'h00; reqValid = 1; reqLevel = 3'd5; autoEoi = 1;
    runSeq();
    // directed: interval 8, spurious (R6)
    interval4 = 0; reqValid = 0;
    runSeq();
    // directed: 16-bit master with cascaded level 3 (R8 R9)
    cpu16 = 1; reqValid = 1; reqLevel = 3'd3; slaveCfg = 8'h08;
    runSeq();
    // directed: buffered slave, ID match then mismatch (R10 R11)
    cpu16 = 0; bufMode = 1; bufMaster = 0; slaveCfg = 8'h06; casIn = 3'd6;
    reqValid = 1; reqLevel = 3'd2;
    runSeq();
    casIn = 3'd1; reqValid = 1;
    runSeq();

    // R12: initStart aborts mid-sequence
    bufMode = 0; rolePin = 1; slaveCfg = 8'h00; cpu16 = 0; reqValid = 1; reqLevel = 3'd1;
    @(negedge clk) ackN = 1'b0;
    @(negedge clk) ackN = 1'b1;
    @(negedge clk) initStart = 1'b1;
    @(negedge clk) initStart = 1'b0;
    runSeq(); // must restart at the opcode pulse

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      randCfg();
      runSeq();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule